// File: doc/BRIEF.md
# Staged Power Switch Ramp Controller

This block sequences the 8-bit control code of one processor core's power-switch clamp. A power sequencer asks it to open or close the switch. Opening walks through a short staircase of partial codes so that only a few switch segments turn on at a time, which limits the inrush current into the core rail. Closing drops every segment in a single step. The block counts a dwell at every code using a 1 µs strobe from the system timer. It reports `busy` while a ramp runs and pulses `done` once the ramp is over.

The code `0xFF` means fully closed (core unpowered) and `0x00` means fully open. An open request made while the switch is already fully open completes at once and leaves the code alone. Requests that arrive while a ramp is running are dropped.

The controller has three states. In `IDLE` nothing is counted. `OPEN_DWELL` holds one staircase code while its dwell runs. `CLOSE_DWELL` holds the closed code while the settle dwell runs. The transitions are as follows:
- start-open goes from `IDLE` to `OPEN_DWELL` when an open request arrives and the code is not `0x00`.
- skip-open stays in `IDLE` and pulses `done` when an open request arrives and the code is `0x00`.
- start-close goes from `IDLE` to `CLOSE_DWELL` on a close request.
- step-advance stays in `OPEN_DWELL` and loads the next code when a dwell expires before the last step.
- open-finish goes from `OPEN_DWELL` to `IDLE` when the last dwell expires.
- close-finish goes from `CLOSE_DWELL` to `IDLE` when the settle dwell expires.

Top module: `pwr_ramp_ctrl`

## Requirements
- R1: After reset `sw_code` is 0xFF, `busy` is 0 and `done` is 0.
- R2: An open request from the closed state drives `sw_code` through 0xFF, 0xFE, 0xF8, 0xF0, 0x00, in that order, with no other value in between.
- R3: Each code of the open staircase, the final 0x00 included, is held for exactly DWELL_TICKS `us_tick` strobes before the next code is applied or the ramp ends. Clock cycles without a strobe do not advance the dwell.
- R4: An open request while `sw_code` is 0x00 leaves `sw_code` unchanged and keeps `busy` low. `done` pulses in the cycle after the request.
- R5: A close request sets `sw_code` to 0xFF at the next clock edge, even when it is already 0xFF. The code is held for DWELL_TICKS strobes before the ramp ends.
- R6: While `busy` is high, open and close requests are ignored. `busy` stays high until the running ramp ends, and the ramp's code sequence is not changed by them.
- R7: `done` is a single-cycle pulse. It rises at the same clock edge at which `busy` falls, which is the edge that samples the last strobe of the final dwell.
- R8: When an open and a close request arrive in the same idle cycle, the open request is taken and the close request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| open_req | input | 1 | Request to open the switch (one-cycle pulse) |
| close_req | input | 1 | Request to close the switch (one-cycle pulse) |
| sw_code | output | 8 | Switch clamp control code, 0xFF closed, 0x00 open |
| busy | output | 1 | High while a ramp is in progress |
| done | output | 1 | One-cycle pulse when a ramp or a skipped open completes |

## Verification
The bench builds the block with DWELL_TICKS = 3 instead of the default 10 and fires the strobe every fourth clock. A whole five-step open ramp therefore takes about sixty cycles. This keeps the ramps short enough to repeat many times, and to land stray requests in the middle of open and close dwells. Because the strobe is sparser than the clock, a dwell counted in cycles rather than strobes shows up as a wrong tick count at each step.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

    localparam int CODE_W    = 8;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    localparam logic [CODE_W-1:0] CODE_CLOSED = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_OPEN   = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_OPEN_DWELL  = 2'd1,
        ST_CLOSE_DWELL = 2'd2
    } ramp_state_t;

    // Staircase of partial switch codes used while opening.
    function automatic logic [CODE_W-1:0] open_step_code(input logic [STEP_W-1:0] idx);
        logic [CODE_W-1:0] c;
        unique case (idx)
            3'd0:    c = 8'hFF;
            3'd1:    c = 8'hFE;
            3'd2:    c = 8'hF8;
            3'd3:    c = 8'hF0;
            default: c = CODE_OPEN;
        endcase
        return c;
    endfunction

    function automatic logic code_is_legal(input logic [CODE_W-1:0] c);
        return (c == 8'hFF) || (c == 8'hFE) || (c == 8'hF8) ||
               (c == 8'hF0) || (c == 8'h00);
    endfunction

endpackage

// File: rtl/pwr_ramp_dwell.sv
module pwr_ramp_dwell #(
    parameter int DWELL_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(DWELL_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R3: the strobe count never passes the dwell length
    assert_dwell_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(DWELL_TICKS));

    // R3: cycles without a strobe leave the count alone
    assert_dwell_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pwr_ramp_code.sv
module pwr_ramp_code
    import pwr_ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_step,
    input  logic [STEP_W-1:0] step_idx,
    input  logic              load_closed,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= CODE_CLOSED;
        end else if (load_closed) begin
            code <= CODE_CLOSED;
        end else if (load_step) begin
            code <= open_step_code(step_idx);
        end
    end

    // R2: only staircase codes ever reach the clamp
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        code_is_legal(code));

    // R5: a close load lands fully closed on the next edge
    assert_close_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_closed |=> (code == CODE_CLOSED));

endmodule

// File: rtl/pwr_ramp_fsm.sv
module pwr_ramp_fsm
    import pwr_ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              close_req,
    input  logic              expire,
    input  logic [CODE_W-1:0] code,
    output logic              load_step,
    output logic [STEP_W-1:0] step_idx,
    output logic              load_closed,
    output logic              dwell_run,
    output logic              busy,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    ramp_state_t       state, state_nxt;
    logic [STEP_W-1:0] idx_q, idx_nxt;
    logic              done_q, done_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            idx_q  <= idx_nxt;
            done_q <= done_nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt   = state;
        idx_nxt     = idx_q;
        done_nxt    = 1'b0;
        load_step   = 1'b0;
        load_closed = 1'b0;
        step_idx    = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (open_req) begin
                    if (code == CODE_OPEN) begin
                        done_nxt = 1'b1;                    // skip-open
                    end else begin
                        state_nxt = ST_OPEN_DWELL;          // start-open
                        idx_nxt   = '0;
                        step_idx  = '0;
                        load_step = 1'b1;
                    end
                end else if (close_req) begin
                    state_nxt   = ST_CLOSE_DWELL;           // start-close
                    load_closed = 1'b1;
                end
            end
            ST_OPEN_DWELL: begin
                if (expire) begin
                    if (idx_q == LAST_STEP) begin
                        state_nxt = ST_IDLE;                // open-finish
                        done_nxt  = 1'b1;
                    end else begin
                        idx_nxt   = idx_q + STEP_W'(1);     // step-advance
                        step_idx  = idx_q + STEP_W'(1);
                        load_step = 1'b1;
                    end
                end
            end
            ST_CLOSE_DWELL: begin
                if (expire) begin
                    state_nxt = ST_IDLE;                    // close-finish
                    done_nxt  = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign dwell_run = (state != ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;

    // R7: done lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done never overlaps a running ramp
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: while opening, the code only steps downward
    assert_open_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN_DWELL && $past(state) == ST_OPEN_DWELL) |-> (code <= $past(code)));

    // R6: a close ramp never changes the code
    assert_close_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE_DWELL && $past(state) == ST_CLOSE_DWELL) |-> $stable(code));

    // R4: when idle the clamp rests at an end point
    assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (code == CODE_OPEN || code == CODE_CLOSED));

endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl #(
    parameter int DWELL_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       open_req,
    input  logic       close_req,
    output logic [7:0] sw_code,
    output logic       busy,
    output logic       done
);
    import pwr_ramp_pkg::*;

    logic              expire;
    logic              dwell_run;
    logic              load_step;
    logic              load_closed;
    logic [STEP_W-1:0] step_idx;
    logic [CODE_W-1:0] code;

    pwr_ramp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_req    (open_req),
        .close_req   (close_req),
        .expire      (expire),
        .code        (code),
        .load_step   (load_step),
        .step_idx    (step_idx),
        .load_closed (load_closed),
        .dwell_run   (dwell_run),
        .busy        (busy),
        .done        (done)
    );

    pwr_ramp_dwell #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (dwell_run),
        .tick   (us_tick),
        .expire (expire)
    );

    pwr_ramp_code u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_step   (load_step),
        .step_idx    (step_idx),
        .load_closed (load_closed),
        .code        (code)
    );

    assign sw_code = code;

    // R6: requests seen while busy never end the ramp early
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> busy);

endmodule

// File: tb/sim_pwr_ramp_ctrl.sv
module sim_pwr_ramp_ctrl;
    localparam int DW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       open_req = 1'b0;
    logic       close_req = 1'b0;
    logic [7:0] sw_code;
    logic       busy;
    logic       done;

    always #2 clk = ~clk;

    pwr_ramp_ctrl #(.DWELL_TICKS(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .open_req(open_req), .close_req(close_req),
        .sw_code(sw_code), .busy(busy), .done(done)
    );

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // scoreboard queues
    logic [7:0] q_code[$];
    int         q_ticks[$];
    bit         q_skip[$];
    string      q_tag[$];

    // monitor state
    bit         in_step = 0;
    bit         busy_prev = 0;
    logic [7:0] cur_code = 8'hFF;
    int         tick_cnt = 0;

    task automatic check(input string tag, input bit ok, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_step(input logic [7:0] c, input string tag);
        q_code.push_back(c); q_ticks.push_back(DW); q_skip.push_back(0); q_tag.push_back(tag);
    endtask

    task automatic push_open(input string tag);
        push_step(8'hFF, tag); push_step(8'hFE, tag); push_step(8'hF8, tag);
        push_step(8'hF0, tag); push_step(8'h00, tag);
    endtask

    task automatic push_skip();
        q_code.push_back(8'h00); q_ticks.push_back(0); q_skip.push_back(1); q_tag.push_back("R4");
    endtask

    task automatic close_item(input bit was_skip, input logic [7:0] c, input int t);
        if (q_code.size() == 0) begin
            check("R6", 0, "unexpected ramp event", c, 0);
        end else begin
            logic [7:0] ec = q_code.pop_front();
            int         et = q_ticks.pop_front();
            bit         es = q_skip.pop_front();
            string      tg = q_tag.pop_front();
            check(tg, (ec == c) && (et == t) && (es == was_skip), "step code/ticks",
                  {c, 8'(t), 7'd0, was_skip}, {ec, 8'(et), 7'd0, es});
        end
    endtask

    // Monitor: splits the output into steps and compares against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (busy) check("R7", 0, "busy with done", 1, 0);
                if (in_step) close_item(0, cur_code, tick_cnt);
                else         close_item(1, sw_code, 0);
                in_step = 0;
            end else if (busy && (!busy_prev || sw_code != cur_code)) begin
                if (in_step) close_item(0, cur_code, tick_cnt);
                in_step  = 1;
                cur_code = sw_code;
                tick_cnt = 0;
            end
            if (busy && us_tick) tick_cnt++;
            busy_prev = busy;
        end
    end

    // 1 us strobe every fourth clock
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    end

    task automatic pulse(input bit o, input bit c);
        @(negedge clk);
        open_req = o; close_req = c;
        @(negedge clk);
        open_req = 0; close_req = 0;
    endtask

    task automatic drain(input string tag, input logic [7:0] end_code);
        while (q_code.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(tag, sw_code == end_code, "final code", sw_code, end_code);
        check(tag, busy == 0, "busy after ramp", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", sw_code == 8'hFF, "reset code", sw_code, 8'hFF);
        check("R1", busy == 0, "reset busy", busy, 0);
        check("R1", done == 0, "reset done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R7: staircase open from closed
        push_open("R2");
        pulse(1, 0);
        drain("R2", 8'h00);

        // R4: open while already open is skipped
        push_skip();
        pulse(1, 0);
        check("R4", busy == 0, "busy on skip", busy, 0);
        check("R4", done == 1, "done after skip", done, 1);
        drain("R4", 8'h00);

        // R5: close, then close again while closed
        push_step(8'hFF, "R5");
        pulse(0, 1);
        drain("R5", 8'hFF);
        push_step(8'hFF, "R5");
        pulse(0, 1);
        drain("R5", 8'hFF);

        // R6: stray requests during an open ramp
        push_open("R6");
        pulse(1, 0);
        repeat (9) @(negedge clk);
        pulse(0, 1);
        repeat (17) @(negedge clk);
        pulse(1, 0);
        repeat (5) @(negedge clk);
        check("R6", busy == 1, "busy mid ramp", busy, 1);
        drain("R6", 8'h00);

        // R6: stray open during a close ramp
        push_step(8'hFF, "R6");
        pulse(0, 1);
        repeat (4) @(negedge clk);
        pulse(1, 0);
        drain("R6", 8'hFF);

        // R8: open and close together pick open
        push_open("R8");
        pulse(1, 1);
        drain("R8", 8'h00);

        // R5: close from open
        push_step(8'hFF, "R5");
        pulse(0, 1);
        drain("R5", 8'hFF);

        check("R3", q_code.size() == 0, "queue empty", q_code.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule